// File: doc/BRIEF.md
# Frame-Synchronous Additive Scrambler

This block whitens a serial bit stream by XORing it with a maximal-length pseudorandom sequence. A seven-stage shift register generates the sequence. It feeds back stage 7 XOR stage 6 into stage 1, which gives the polynomial x^7 + x^6 + 1. Every frame restarts the generator from the all-ones state, so a receiver that sees the same frame strobe can regenerate the same sequence. Bits flagged as header travel through unchanged and do not consume sequence bits.

Each bit is offered with a valid qualifier, together with a frame-start strobe and a header flag. The result comes out one registered stage later with its own valid. The operation is its own inverse: the same module, driven with the same framing, descrambles. Because the combination is purely additive, a corrupted line bit corrupts exactly one recovered bit.

Top module: `frame_scrambler`

## Requirements
- R1: The generator is a 7-stage register. Stage 1 receives stage 7 XOR stage 6, every stage shifts one place toward stage 7, and the mask bit applied to data is the current content of stage 7.
- R2: A frame-start strobe loads the generator with all ones. The first payload bit of a frame is therefore inverted (mask 1), and an all-zero payload yields the sequence 1,1,1,1,1,1,1,0,...
- R3: When the strobe and a valid payload bit arrive in the same cycle, the seed load is applied first and that bit uses the freshly seeded state.
- R4: The mask sequence repeats every 127 advancing bits and holds exactly 64 ones per period.
- R5: A valid bit presented with the header flag high leaves unchanged.
- R6: The generator advances only on cycles with valid high and the header flag low. Idle cycles and header bits do not shift the mask sequence.
- R7: The output valid equals the input valid one clock later, and the output bit belongs to the input bit of that same earlier cycle.
- R8: The output bit is 0 whenever the output valid is low.
- R9: Passing the output through a second instance with identical framing restores the original stream, header bits included.
- R10: A single flipped bit in the scrambled stream flips exactly one bit of the descrambled stream, in the same position.
- R11: After reset both outputs are low and the generator holds the all-ones seed, so payload sent before any strobe starts with mask 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| din | input | 1 | Serial data bit |
| din_vld | input | 1 | Qualifies din |
| frm_start | input | 1 | Frame boundary strobe; reseeds the generator |
| hdr_on | input | 1 | Current bit belongs to the unscrambled header |
| dout | output | 1 | Scrambled (or descrambled) bit |
| dout_vld | output | 1 | Qualifies dout, one cycle after din_vld |

## Verification
The hardest case to reach from the ports is a mask sequence that has been held by idle cycles and header bits and must then resume at exactly the right phase. A slip of one position is invisible unless the payload is long and known. The stimulus covers this with a reference generator in the bench that advances only on payload bits. It interleaves invalid gaps and header runs inside long all-zero and random payloads, so any extra or missing shift shows up as a bit mismatch. The strobe that coincides with the first payload bit is driven on purpose to expose an off-by-one seed load. The period and balance of the sequence come from a 254-bit all-zero payload.

// File: rtl/scr_pkg.sv
package scr_pkg;
   // One serial beat as seen at the block input.
   typedef struct packed {
      logic d;
      logic vld;
      logic fs;
      logic hdr;
   } scr_beat_t;
endpackage

// File: rtl/scr_lfsr.sv
module scr_lfsr #(
   parameter int         W      = 7,
   parameter int         TAP_HI = 7,
   parameter int         TAP_LO = 6,
   parameter logic [W-1:0] SEED = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic         adv,
   output logic         mask,
   output logic [W-1:0] state
);
   localparam int HI_IX = TAP_HI - 1;
   localparam int LO_IX = TAP_LO - 1;

   logic [W-1:0] st_q;
   logic [W-1:0] eff;
   logic [W-1:0] stepped;

   // Reseed wins over the stored state within the same cycle.
   assign eff     = load ? SEED : st_q;
   assign stepped = {eff[W-2:0], eff[HI_IX] ^ eff[LO_IX]};
   assign mask    = eff[W-1];
   assign state   = st_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    st_q <= SEED;
      else if (adv)  st_q <= stepped;
      else if (load) st_q <= SEED;
   end
endmodule

// File: rtl/scr_mix.sv
module scr_mix #(
   parameter bit IDLE_ZERO = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   input  logic vld,
   input  logic apply,
   input  logic mask,
   output logic q,
   output logic q_vld
);
   logic mixed;
   logic nxt;

   assign mixed = d ^ (apply & mask);

   generate
      if (IDLE_ZERO) begin : g_idle_zero
         assign nxt = vld & mixed;
      end else begin : g_idle_pass
         assign nxt = mixed;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q     <= 1'b0;
         q_vld <= 1'b0;
      end else begin
         q     <= nxt;
         q_vld <= vld;
      end
   end
endmodule

// File: rtl/frame_scrambler.sv
module frame_scrambler #(
   parameter int         LFSR_W = 7,
   parameter int         TAP_HI = 7,
   parameter int         TAP_LO = 6,
   parameter logic [LFSR_W-1:0] SEED = '1,
   parameter bit         IDLE_ZERO = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   input  logic din_vld,
   input  logic frm_start,
   input  logic hdr_on,
   output logic dout,
   output logic dout_vld
);
   import scr_pkg::*;

   generate
      if (TAP_HI != LFSR_W) begin : g_bad_hi
         $error("frame_scrambler: TAP_HI must equal LFSR_W");
      end
      if (TAP_LO < 1 || TAP_LO >= TAP_HI) begin : g_bad_lo
         $error("frame_scrambler: TAP_LO out of range");
      end
      if (SEED == '0) begin : g_bad_seed
         $error("frame_scrambler: all-zero seed locks the generator");
      end
   endgenerate

   scr_beat_t beat;
   logic      payload;
   logic      mask_w;
   logic [LFSR_W-1:0] st_w;

   assign beat    = '{d: din, vld: din_vld, fs: frm_start, hdr: hdr_on};
   assign payload = beat.vld & ~beat.hdr;

   scr_lfsr #(
      .W(LFSR_W), .TAP_HI(TAP_HI), .TAP_LO(TAP_LO), .SEED(SEED)
   ) u_gen (
      .clk(clk), .rst_n(rst_n), .load(beat.fs), .adv(payload),
      .mask(mask_w), .state(st_w)
   );

   scr_mix #(.IDLE_ZERO(IDLE_ZERO)) u_mix (
      .clk(clk), .rst_n(rst_n), .d(beat.d), .vld(beat.vld),
      .apply(payload), .mask(mask_w), .q(dout), .q_vld(dout_vld)
   );
endmodule

// File: rtl/scr_chk.sv
module scr_chk #(
   parameter int W = 7,
   parameter logic [W-1:0] SEED = '1
) (
   input logic         clk,
   input logic         rst_n,
   input logic         din,
   input logic         din_vld,
   input logic         frm_start,
   input logic         hdr_on,
   input logic         dout,
   input logic         dout_vld,
   input logic [W-1:0] st
);
   // R7: valid follows the input one cycle later
   a_r7_vld_delay: assert property (@(posedge clk) disable iff (!rst_n)
      din_vld |=> dout_vld);
   a_r7_no_vld: assert property (@(posedge clk) disable iff (!rst_n)
      !din_vld |=> !dout_vld);
   // R5: header bits unchanged
   a_r5_hdr_pass: assert property (@(posedge clk) disable iff (!rst_n)
      (din_vld && hdr_on) |=> (dout == $past(din)));
   // R3: strobe with payload bit uses the seed's last stage
   a_r3_seed_first: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_start && din_vld && !hdr_on) |=> (dout == ($past(din) ^ SEED[W-1])));
   // R6: generator holds when nothing advances it
   a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!frm_start && !(din_vld && !hdr_on)) |=> $stable(st));
   // R8: idle output is zero
   a_r8_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !din_vld |=> !dout);
endmodule

bind frame_scrambler scr_chk #(.W(LFSR_W), .SEED(SEED)) u_chk (
   .clk(clk), .rst_n(rst_n), .din(din), .din_vld(din_vld),
   .frm_start(frm_start), .hdr_on(hdr_on), .dout(dout),
   .dout_vld(dout_vld), .st(st_w)
);

// File: tb/frame_scrambler_tb_top.sv
`timescale 1ns/1ps
module frame_scrambler_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic din = 1'b0, din_vld = 1'b0, frm_start = 1'b0, hdr_on = 1'b0;
   logic dout, dout_vld;

   int tests = 0;
   int fails = 0;
   int cycles = 0;

   bit exp_q[$];
   bit cap_q[$];
   bit orig_q[$];
   bit scr_q[$];
   logic [7:1] m = 7'h7f;   // reference generator, stage index 1..7

   always #2 clk = ~clk;

   frame_scrambler dut_i (
      .clk(clk), .rst_n(rst_n), .din(din), .din_vld(din_vld),
      .frm_start(frm_start), .hdr_on(hdr_on), .dout(dout), .dout_vld(dout_vld)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Driver: applies one beat and pushes the expected output bit.
   task automatic send(input bit d, input bit v, input bit fs, input bit hd,
                       input bit use_ov, input bit ov);
      bit e;
      @(negedge clk);
      din = d; din_vld = v; frm_start = fs; hdr_on = hd;
      if (fs) m = 7'h7f;
      e = d;
      if (v && !hd) begin
         e = d ^ m[7];
         m = {m[6:1], m[7] ^ m[6]};
      end
      if (v) exp_q.push_back(use_ov ? ov : e);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) send(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
   endtask

   // Monitor: compares each valid output against the scoreboard.
   always @(negedge clk) begin
      #1;
      if (rst_n) begin
         if (!dout_vld) chk(dout == 1'b0, "R8 idle output", dout, 0);
         else begin
            cap_q.push_back(dout);
            if (exp_q.size() == 0) chk(1'b0, "R7 unexpected valid", 1, 0);
            else begin
               bit e;
               e = exp_q.pop_front();
               chk(dout == e, "R1/R5/R6/R9 data", dout, e);
            end
         end
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles == 150000) begin
         chk(1'b0, "watchdog", cycles, 0);
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      int ones;
      repeat (3) @(negedge clk);
      // R11: reset state
      chk(dout == 1'b0 && dout_vld == 1'b0, "R11 reset outputs", {dout, dout_vld}, 0);
      rst_n = 1'b1;
      // R11: payload before any strobe uses the seed (first bit inverted)
      for (int i = 0; i < 10; i++) send(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
      idle(2);
      chk(cap_q.size() == 10 && cap_q[0] == 1'b1, "R11 seed after reset", cap_q[0], 1);

      // R1 R2 R3 R4: strobe with first zero bit, 254 zeros
      cap_q.delete();
      for (int i = 0; i < 254; i++) send(1'b0, 1'b1, i == 0, 1'b0, 1'b0, 1'b0);
      idle(2);
      chk(cap_q.size() == 254, "R4 captured length", cap_q.size(), 254);
      chk(cap_q[0] && cap_q[6] && !cap_q[7], "R2 sequence head", cap_q[7], 0);
      ones = 0;
      for (int i = 0; i < 127; i++) begin
         ones += cap_q[i];
         chk(cap_q[i] == cap_q[i+127], "R4 period 127", cap_q[i+127], cap_q[i]);
      end
      chk(ones == 64, "R4 ones per period", ones, 64);

      // R5 R6: header run, then payload with gaps
      for (int i = 0; i < 6; i++) send(i[0], 1'b1, i == 0, 1'b1, 1'b0, 1'b0);
      for (int i = 0; i < 40; i++) begin
         send(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
         if (i % 7 == 3) idle(3);
         if (i == 20) send(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
      end
      idle(2);

      // R9: scramble random frame, then descramble its output
      orig_q.delete(); cap_q.delete();
      for (int i = 0; i < 80; i++) begin
         bit d; d = 1'($urandom);
         orig_q.push_back(d);
         send(d, 1'b1, i == 0, i < 4, 1'b0, 1'b0);
         if (i == 30) idle(2);
      end
      idle(2);
      scr_q = cap_q;
      for (int i = 0; i < 80; i++)
         send(scr_q[i], 1'b1, i == 0, i < 4, 1'b1, orig_q[i]);   // R9
      idle(2);

      // R10: one line error flips only one recovered bit
      scr_q[45] = ~scr_q[45];
      for (int i = 0; i < 80; i++)
         send(scr_q[i], 1'b1, i == 0, i < 4, 1'b1, orig_q[i] ^ (i == 45));  // R10
      idle(3);

      chk(exp_q.size() == 0, "R7 scoreboard drained", exp_q.size(), 0);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule